// File: doc/BRIEF.md
# Adaptive Quadrature-Error Frequency Tracker

This block keeps a phase and frequency estimate aligned with a single-phase signal sampled at a fixed rate. The signal arrives as an orthogonal pair of signed samples, alpha and beta. On each sample strobe the block rotates the pair by its current phase estimate into a direct (d) and a quadrature (q) component. The quadrature part is the error signal. It corrects the frequency word through a direct gain on q and a gain on the change of q since the last sample. There is no proportional-integral loop filter. The new frequency is saturated, clamped to a range the caller supplies, and added as a phase step to a wrapping phase accumulator.

The frequency word is in rad/s with 4 fractional bits. The phase word is an unsigned 24-bit fraction of a full turn. At the default operating point the sample rate is 10 kHz and the nominal input is 400 Hz. Sine and cosine of the phase come from an internal quarter-wave table that is addressed by the top 10 phase bits. The two gains and the clamp bounds are inputs, so the loop can be retuned while it runs.

Top module: `quad_freq_tracker`

## Requirements
- R1: While rst_ni is low, and after it is released until the first strobe, phase_o is 0 and d_o and q_o are 0. freq_o is round(2*pi*400*16) = 40212.
- R2: On a strobe, d_o becomes floor((alpha*cos + beta*sin)/2^15) and q_o becomes floor((beta*cos - alpha*sin)/2^15). sin and cos are the table values for the phase held before that strobe.
- R3: sin_o follows phase_o without a clock. Take a = phase_o[23:14], k = a[7:0], and T(j) = round(32767*sin(2*pi*(j+0.5)/1024)). The magnitude is T(k) when a[8] is 0 and T(255-k) when a[8] is 1. It is negative when a[9] is 1. cos_o is the same function at address (a+256) mod 1024. Neither output is ever -32768.
- R4: On a strobe the correction is floor((kw_i*q + kff_i*(q - q_prev))/2^11). Here q is the new quadrature value and q_prev is the q of the previous strobe, or 0 after reset. The correction is added to freq_o.
- R5: The correction is saturated to the signed 24-bit range [-8388608, 8388607] before it is added to the frequency.
- R6: If the sum exceeds wmax_i, the new frequency is wmax_i. Otherwise, if the sum is below wmin_i, it is wmin_i. The wmax_i test has priority.
- R7: On a strobe, phase_o advances modulo 2^24 by floor(w_new*K/2^16). w_new is the frequency just written and K = round(2^40/(2*pi*10000*16)).
- R8: Without a strobe, phase_o, freq_o, d_o and q_o hold their values. Sample, gain and bound inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Sample strobe, one cycle per sample |
| alpha_i | input | 16 | In-phase input sample, signed Q1.15 |
| beta_i | input | 16 | Orthogonal input sample, signed Q1.15 |
| kw_i | input | 20 | Direct gain on q, unsigned, rad/s per unit |
| kff_i | input | 20 | Gain on the change of q, unsigned |
| wmin_i | input | 24 | Lower frequency bound, signed, rad/s Q.4 |
| wmax_i | input | 24 | Upper frequency bound, signed, rad/s Q.4 |
| phase_o | output | 24 | Phase estimate, unsigned fraction of a turn |
| freq_o | output | 24 | Frequency estimate, signed rad/s Q.4 |
| d_o | output | 18 | Direct component of the last strobe, signed |
| q_o | output | 18 | Quadrature component of the last strobe, signed |
| sin_o | output | 16 | Sine of phase_o, signed Q1.15 |
| cos_o | output | 16 | Cosine of phase_o, signed Q1.15 |

## Verification
The assertions check four properties on every cycle. Registered outputs hold between strobes. A strobe never leaves the frequency outside a well-ordered bound pair. The signs of sin_o and cos_o agree with the phase quadrant. Neither table output reaches the most negative code. The exact arithmetic can only be shown by the bench scenarios, which run a bit-exact model and compare against it: the rotation, the difference term on q, the saturation ahead of the clamp, the priority when the bounds are crossed, and the phase wraparound. These scenarios are tone runs at 400 Hz and after a step to 405 Hz, forced saturation with maximum gains, inverted bounds, and randomized sweeps of gains and bounds.

// File: rtl/qtrk_pkg.sv
package qtrk_pkg;

  localparam real PI = 3.14159265358979;

  // rounded quarter-wave sample at half-step offset
  function automatic int qtrk_quarter_sine(int k, int aw, int amp);
    real ang;
    ang = 2.0 * PI * (real'(k) + 0.5) / real'(longint'(1) << aw);
    return $rtoi(real'(amp) * $sin(ang) + 0.5);
  endfunction

  function automatic int qtrk_inc_gain(int ph_w, int frac, int fs, int sh);
    real num;
    num = real'(longint'(1) << ph_w) * real'(longint'(1) << sh);
    return $rtoi(num / (2.0 * PI * real'(fs) * real'(longint'(1) << frac)) + 0.5);
  endfunction

  function automatic int qtrk_nom_freq(int hz, int frac);
    return $rtoi(2.0 * PI * real'(hz) * real'(longint'(1) << frac) + 0.5);
  endfunction

endpackage

// File: rtl/qtrk_sincos_lut.sv
module qtrk_sincos_lut
  import qtrk_pkg::*;
#(
  parameter int LUT_AW = 10,
  parameter int TRIG_W = 16
) (
  input  logic [LUT_AW-1:0]        addr_i,
  output logic signed [TRIG_W-1:0] sin_o,
  output logic signed [TRIG_W-1:0] cos_o
);
  localparam int QD  = 2 ** (LUT_AW - 2);
  localparam int AMP = 2 ** (TRIG_W - 1) - 1;

  logic [TRIG_W-2:0]        quarter [QD];
  logic signed [TRIG_W-1:0] trig    [2];

  for (genvar i = 0; i < QD; i++) begin : g_tab
    assign quarter[i] = (TRIG_W-1)'(qtrk_quarter_sine(i, LUT_AW, AMP));
  end

  // port 0 reads sine, port 1 reads a quarter turn ahead (cosine)
  for (genvar p = 0; p < 2; p++) begin : g_port
    localparam logic [LUT_AW-1:0] OFS = LUT_AW'(p * QD);
    logic [LUT_AW-1:0] a;
    logic [LUT_AW-3:0] k;
    logic [LUT_AW-3:0] idx;
    logic [TRIG_W-1:0] mag;
    assign a   = addr_i + OFS;
    assign k   = a[LUT_AW-3:0];
    assign idx = a[LUT_AW-2] ? ~k : k;
    assign mag = {1'b0, quarter[idx]};
    assign trig[p] = a[LUT_AW-1] ? -signed'(mag) : signed'(mag);
  end

  assign sin_o = trig[0];
  assign cos_o = trig[1];
endmodule

// File: rtl/qtrk_dq_rotator.sv
module qtrk_dq_rotator #(
  parameter int IN_W   = 16,
  parameter int TRIG_W = 16,
  parameter int DQ_W   = 18
) (
  input  logic signed [IN_W-1:0]   alpha_i,
  input  logic signed [IN_W-1:0]   beta_i,
  input  logic signed [TRIG_W-1:0] sin_i,
  input  logic signed [TRIG_W-1:0] cos_i,
  output logic signed [DQ_W-1:0]   d_o,
  output logic signed [DQ_W-1:0]   q_o
);
  localparam int PROD_W = IN_W + TRIG_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam int SH     = TRIG_W - 1;

  logic signed [PROD_W-1:0] p_ac, p_bs, p_bc, p_as;

  assign p_ac = alpha_i * cos_i;
  assign p_bs = beta_i * sin_i;
  assign p_bc = beta_i * cos_i;
  assign p_as = alpha_i * sin_i;

  assign d_o = DQ_W'((SUM_W'(p_ac) + SUM_W'(p_bs)) >>> SH);
  assign q_o = DQ_W'((SUM_W'(p_bc) - SUM_W'(p_as)) >>> SH);
endmodule

// File: rtl/qtrk_freq_adapt.sv
module qtrk_freq_adapt #(
  parameter int DQ_W    = 18,
  parameter int GAIN_W  = 20,
  parameter int FREQ_W  = 24,
  parameter int GAIN_SH = 11,
  parameter logic signed [FREQ_W-1:0] W_RST = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DQ_W-1:0]   q_i,
  input  logic [GAIN_W-1:0]        kw_i,
  input  logic [GAIN_W-1:0]        kff_i,
  input  logic signed [FREQ_W-1:0] wmin_i,
  input  logic signed [FREQ_W-1:0] wmax_i,
  output logic signed [FREQ_W-1:0] w_next_o,
  output logic signed [FREQ_W-1:0] w_o
);
  localparam int ACC_W = GAIN_W + DQ_W + 3;
  localparam logic signed [ACC_W-1:0] C_MAX = ACC_W'(2 ** (FREQ_W - 1) - 1);
  localparam logic signed [ACC_W-1:0] C_MIN = -C_MAX - ACC_W'(1);

  logic signed [DQ_W-1:0]        q_prev_q;
  logic signed [FREQ_W-1:0]      w_q;
  logic signed [GAIN_W:0]        kw_s, kff_s;
  logic signed [DQ_W:0]          q_diff;
  logic signed [GAIN_W+DQ_W:0]   p_kw;
  logic signed [GAIN_W+DQ_W+1:0] p_kff;
  logic signed [ACC_W-1:0]       raw, shifted;
  logic signed [FREQ_W-1:0]      corr;
  logic signed [FREQ_W:0]        sum_w;

  assign kw_s   = signed'({1'b0, kw_i});
  assign kff_s  = signed'({1'b0, kff_i});
  assign q_diff = (DQ_W+1)'(q_i) - (DQ_W+1)'(q_prev_q);
  assign p_kw   = kw_s * q_i;
  assign p_kff  = kff_s * q_diff;
  assign raw    = ACC_W'(p_kw) + ACC_W'(p_kff);
  assign shifted = raw >>> GAIN_SH;

  // saturate before the add so the sum cannot wrap
  always_comb begin
    if (shifted > C_MAX)      corr = FREQ_W'(C_MAX);
    else if (shifted < C_MIN) corr = FREQ_W'(C_MIN);
    else                      corr = FREQ_W'(shifted);
  end

  assign sum_w = (FREQ_W+1)'(w_q) + (FREQ_W+1)'(corr);

  always_comb begin
    if (sum_w > (FREQ_W+1)'(wmax_i))      w_next_o = wmax_i;
    else if (sum_w < (FREQ_W+1)'(wmin_i)) w_next_o = wmin_i;
    else                                  w_next_o = FREQ_W'(sum_w);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q      <= W_RST;
      q_prev_q <= '0;
    end else if (valid_i) begin
      w_q      <= w_next_o;
      q_prev_q <= q_i;
    end
  end

  assign w_o = w_q;
endmodule

// File: rtl/qtrk_phase_acc.sv
module qtrk_phase_acc #(
  parameter int FREQ_W = 24,
  parameter int PH_W   = 24,
  parameter int INC_SH = 16,
  parameter int INC_K  = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [FREQ_W-1:0] w_next_i,
  output logic [PH_W-1:0]          phase_o
);
  localparam int FULL_W = FREQ_W + 32;

  logic [PH_W-1:0] inc;
  logic [PH_W-1:0] phase_q;

  assign inc = PH_W'((FULL_W'(w_next_i) * FULL_W'(INC_K)) >>> INC_SH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_q <= '0;
    else if (valid_i) phase_q <= phase_q + inc;  // wraps modulo one turn
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/quad_freq_tracker.sv
module quad_freq_tracker
  import qtrk_pkg::*;
#(
  parameter int IN_W      = 16,
  parameter int TRIG_W    = 16,
  parameter int DQ_W      = 18,
  parameter int GAIN_W    = 20,
  parameter int FREQ_W    = 24,
  parameter int FREQ_FRAC = 4,
  parameter int PH_W      = 24,
  parameter int LUT_AW    = 10,
  parameter int SAMPLE_HZ = 10000,
  parameter int NOM_HZ    = 400
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [IN_W-1:0]   alpha_i,
  input  logic signed [IN_W-1:0]   beta_i,
  input  logic [GAIN_W-1:0]        kw_i,
  input  logic [GAIN_W-1:0]        kff_i,
  input  logic signed [FREQ_W-1:0] wmin_i,
  input  logic signed [FREQ_W-1:0] wmax_i,
  output logic [PH_W-1:0]          phase_o,
  output logic signed [FREQ_W-1:0] freq_o,
  output logic signed [DQ_W-1:0]   d_o,
  output logic signed [DQ_W-1:0]   q_o,
  output logic signed [TRIG_W-1:0] sin_o,
  output logic signed [TRIG_W-1:0] cos_o
);
  localparam int GAIN_SH = TRIG_W - 1 - FREQ_FRAC;
  localparam int INC_SH  = 16;
  localparam int INC_K   = qtrk_inc_gain(PH_W, FREQ_FRAC, SAMPLE_HZ, INC_SH);
  localparam logic signed [FREQ_W-1:0] W_RST = FREQ_W'(qtrk_nom_freq(NOM_HZ, FREQ_FRAC));

  logic [PH_W-1:0]          phase;
  logic signed [TRIG_W-1:0] sin_w, cos_w;
  logic signed [DQ_W-1:0]   d_w, q_w;
  logic signed [DQ_W-1:0]   d_q, q_q;
  logic signed [FREQ_W-1:0] w_next, w_cur;

  qtrk_sincos_lut #(.LUT_AW(LUT_AW), .TRIG_W(TRIG_W)) u_lut (
    .addr_i (phase[PH_W-1 -: LUT_AW]),
    .sin_o  (sin_w),
    .cos_o  (cos_w)
  );

  qtrk_dq_rotator #(.IN_W(IN_W), .TRIG_W(TRIG_W), .DQ_W(DQ_W)) u_rot (
    .alpha_i (alpha_i),
    .beta_i  (beta_i),
    .sin_i   (sin_w),
    .cos_i   (cos_w),
    .d_o     (d_w),
    .q_o     (q_w)
  );

  qtrk_freq_adapt #(
    .DQ_W(DQ_W), .GAIN_W(GAIN_W), .FREQ_W(FREQ_W),
    .GAIN_SH(GAIN_SH), .W_RST(W_RST)
  ) u_freq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .q_i      (q_w),
    .kw_i     (kw_i),
    .kff_i    (kff_i),
    .wmin_i   (wmin_i),
    .wmax_i   (wmax_i),
    .w_next_o (w_next),
    .w_o      (w_cur)
  );

  qtrk_phase_acc #(
    .FREQ_W(FREQ_W), .PH_W(PH_W), .INC_SH(INC_SH), .INC_K(INC_K)
  ) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .w_next_i (w_next),
    .phase_o  (phase)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q <= '0;
      q_q <= '0;
    end else if (valid_i) begin
      d_q <= d_w;
      q_q <= q_w;
    end
  end

  assign phase_o = phase;
  assign freq_o  = w_cur;
  assign d_o     = d_q;
  assign q_o     = q_q;
  assign sin_o   = sin_w;
  assign cos_o   = cos_w;
endmodule

// File: rtl/quad_freq_tracker_chk.sv
module quad_freq_tracker_chk #(
  parameter int TRIG_W = 16,
  parameter int DQ_W   = 18,
  parameter int FREQ_W = 24,
  parameter int PH_W   = 24
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     valid_i,
  input logic signed [FREQ_W-1:0] wmin_i,
  input logic signed [FREQ_W-1:0] wmax_i,
  input logic [PH_W-1:0]          phase_o,
  input logic signed [FREQ_W-1:0] freq_o,
  input logic signed [DQ_W-1:0]   d_o,
  input logic signed [DQ_W-1:0]   q_o,
  input logic signed [TRIG_W-1:0] sin_o,
  input logic signed [TRIG_W-1:0] cos_o
);
  localparam logic signed [TRIG_W-1:0] T_MIN = {1'b1, {(TRIG_W-1){1'b0}}};

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(phase_o) && $stable(freq_o) && $stable(d_o) && $stable(q_o)); // R8

  AST_FREQ_IN_BOUNDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (wmin_i <= wmax_i) |=> (freq_o >= $past(wmin_i)) && (freq_o <= $past(wmax_i))); // R6

  AST_SIN_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o[PH_W-1] == 1'b0) == (sin_o > 0)); // R3

  AST_COS_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_o[PH_W-1] ^ phase_o[PH_W-2]) == 1'b0) == (cos_o > 0)); // R3

  AST_TRIG_NO_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sin_o != T_MIN) && (cos_o != T_MIN)); // R3
endmodule

bind quad_freq_tracker quad_freq_tracker_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .wmin_i  (wmin_i),
  .wmax_i  (wmax_i),
  .phase_o (phase_o),
  .freq_o  (freq_o),
  .d_o     (d_o),
  .q_o     (q_o),
  .sin_o   (sin_o),
  .cos_o   (cos_o)
);

// File: tb/quad_freq_tracker_tb_top.sv
`timescale 1ns/1ps
module quad_freq_tracker_tb_top;
  localparam real    PI_R  = 3.14159265358979;
  localparam longint MASK  = 64'd16777215;
  localparam longint K_INC = longint'($rtoi(16777216.0 * 65536.0 / (2.0 * PI_R * 10000.0 * 16.0) + 0.5));
  localparam longint NOM_W = longint'($rtoi(2.0 * PI_R * 400.0 * 16.0 + 0.5));

  logic clk = 1'b0;
  logic rst_n;
  logic valid;
  logic signed [15:0] alpha, beta;
  logic [19:0] kw, kff;
  logic signed [23:0] wmin, wmax;
  logic [23:0] phase_o;
  logic signed [23:0] freq_o;
  logic signed [17:0] d_o, q_o;
  logic signed [15:0] sin_o, cos_o;

  int n_chk = 0;
  int n_fail = 0;
  longint m_th, m_w, m_qp, m_d, m_q;
  real ph_in = 0.0;

  always #2 clk = ~clk;

  quad_freq_tracker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid),
    .alpha_i(alpha), .beta_i(beta), .kw_i(kw), .kff_i(kff),
    .wmin_i(wmin), .wmax_i(wmax),
    .phase_o(phase_o), .freq_o(freq_o), .d_o(d_o), .q_o(q_o),
    .sin_o(sin_o), .cos_o(cos_o)
  );

  function automatic longint tab(longint k);
    return longint'($rtoi(32767.0 * $sin(2.0 * PI_R * (real'(k) + 0.5) / 1024.0) + 0.5));
  endfunction

  function automatic longint trig(longint th);
    longint a, k, v;
    a = (th >> 14) & 1023;
    k = a & 255;
    if ((a & 256) != 0) k = 255 - k;
    v = tab(k);
    return ((a & 512) != 0) ? -v : v;
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_th = 0; m_w = NOM_W; m_qp = 0; m_d = 0; m_q = 0;
  endtask

  task automatic model_step(longint a, longint b);
    longint s, c, raw, cr, wn;
    s = trig(m_th);
    c = trig((m_th + 4194304) & MASK);
    m_d = (a * c + b * s) >>> 15;
    m_q = (b * c - a * s) >>> 15;
    raw = longint'(kw) * m_q + longint'(kff) * (m_q - m_qp);
    cr = raw >>> 11;
    if (cr > 8388607) cr = 8388607;
    else if (cr < -8388608) cr = -8388608;
    wn = m_w + cr;
    if (wn > longint'(wmax)) wn = longint'(wmax);
    else if (wn < longint'(wmin)) wn = longint'(wmin);
    m_w = wn;
    m_th = (m_th + (((wn * K_INC) >>> 16) & MASK)) & MASK;
    m_qp = m_q;
  endtask

  task automatic check_all(string ftag);
    chk("R7", "phase", longint'(phase_o), m_th);
    chk(ftag, "freq", longint'(freq_o), m_w);
    chk("R2", "d", longint'(d_o), m_d);
    chk("R2", "q", longint'(q_o), m_q);
    chk("R3", "sin", longint'(sin_o), trig(m_th));
    chk("R3", "cos", longint'(cos_o), trig((m_th + 4194304) & MASK));
  endtask

  task automatic apply(int a, int b, string ftag);
    @(negedge clk);
    alpha = 16'(a); beta = 16'(b); valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    model_step(longint'(alpha), longint'(beta));
    check_all(ftag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
  endtask

  task automatic run_tone(real hz, int n);
    for (int i = 0; i < n; i++) begin
      ph_in = ph_in + 2.0 * PI_R * hz / 10000.0;
      if (ph_in > 2.0 * PI_R) ph_in = ph_in - 2.0 * PI_R;
      apply($rtoi(16384.0 * $cos(ph_in)), $rtoi(16384.0 * $sin(ph_in)), "R4");
    end
  endtask

  task automatic idle_test(int n);
    logic [19:0] kw_s, kff_s;
    logic signed [23:0] wmin_s, wmax_s;
    kw_s = kw; kff_s = kff; wmin_s = wmin; wmax_s = wmax;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 1'b0;
      alpha = 16'($urandom); beta = 16'($urandom);
      kw = 20'($urandom); kff = 20'($urandom);
      wmin = 24'($urandom); wmax = 24'($urandom);
      @(negedge clk);
      chk("R8", "phase held", longint'(phase_o), m_th);
      chk("R8", "freq held", longint'(freq_o), m_w);
      chk("R8", "d held", longint'(d_o), m_d);
      chk("R8", "q held", longint'(q_o), m_q);
    end
    kw = kw_s; kff = kff_s; wmin = wmin_s; wmax = wmax_s;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; valid = 1'b0; alpha = '0; beta = '0;
    kw = 20'd2000; kff = 20'd10000;
    wmin = 24'sd30159; wmax = 24'sd50265;
    model_reset();

    // R1 reset state
    do_reset();
    chk("R1", "phase", longint'(phase_o), 0);
    chk("R1", "freq", longint'(freq_o), 40212);
    chk("R1", "d", longint'(d_o), 0);
    chk("R1", "q", longint'(q_o), 0);
    check_all("R1");

    // R8 inputs ignored without strobe
    idle_test(20);

    // R4 tone at 400 Hz, then step to 405 Hz
    run_tone(400.0, 400);
    run_tone(405.0, 400);
    idle_test(10);

    // R6 clamp and its priority
    kw = '0; kff = '0;
    wmin = 24'sd30000; wmax = 24'sd40000;
    apply(1000, -2000, "R6");
    chk("R6", "clamp to wmax", longint'(freq_o), 40000);
    wmin = 24'sd45000; wmax = 24'sd50000;
    apply(-500, 700, "R6");
    chk("R6", "clamp to wmin", longint'(freq_o), 45000);
    wmin = 24'sd50000; wmax = 24'sd30000;
    apply(300, 300, "R6");
    chk("R6", "wmax priority", longint'(freq_o), 30000);

    // R5 correction saturation ahead of the clamp
    do_reset();
    kw = 20'hFFFFF; kff = 20'hFFFFF;
    wmin = -24'sd8388608; wmax = 24'sd8388607;
    apply(0, -32768, "R5");
    chk("R5", "saturated correction", longint'(freq_o), -8348396);
    for (int i = 0; i < 300; i++) apply(int'($signed(16'($urandom))), int'($signed(16'($urandom))), "R5");

    // R4 R6 R7 randomized gains and bounds
    for (int i = 0; i < 1500; i++) begin
      if ((i % 50) == 0) begin
        kw = 20'($urandom_range(0, 6000));
        kff = 20'($urandom_range(0, 30000));
        wmin = 24'($urandom_range(0, 40000)) - 24'sd20000;
        wmax = 24'($urandom_range(20000, 90000));
      end
      apply(int'($signed(16'($urandom))), int'($signed(16'($urandom))), "R4");
    end
    idle_test(10);

    // R1 reset after activity
    do_reset();
    chk("R1", "phase after rerun", longint'(phase_o), 0);
    chk("R1", "freq after rerun", longint'(freq_o), NOM_W);
    chk("R1", "q after rerun", longint'(q_o), 0);
    apply(0, 0, "R4");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule